// File: doc/BRIEF.md
# Entropy Unit Control-Word Programming Sequencer

This block loads the shared control register of one entropy unit. Each of the three noise cells has its own oscillator setting, and the register is the only way to load it. On a start pulse the block captures the three oscillator settings and the accumulation wait count. From them it builds four 64-bit control words and writes them to the register one at a time, in index order.

After each write the block polls a read-back status port until the write is confirmed. A busy answer is retried after a fixed short delay. A would-block answer is retried after the tick count that comes back with it. Each kind of answer has its own retry budget, and both budgets are refilled for every word. A hard-error answer, or a spent budget, ends the sequence with an error and leaves the remaining words unwritten.

The host uses a plain start/busy/done/error handshake. Done and error stay set until the next accepted start. The register and the status responder sit outside the block.

Top module: `entropy_ctl_seq`

## Requirements
- R1: A start pulse seen while idle raises busy and clears done and error in the next cycle. With every poll answered OK, exactly four words are written in index order 0,1,2,3, after which busy falls and done rises with error low.
- R2: Word k for k in 0..2 has only enable bit k set among bits [2:0], and carries oscillator setting k (bits [2k+1:2k] of the oscillator configuration input) in bits [5:4].
- R3: Word 3 has enable bits [2:0] = 3'b111 and oscillator field [5:4] = 0.
- R4: Every word carries the common base: the select field [7:6] = 2, the conditioning mode bit [3] = 1, and the captured wait count in [23:8]. All other bits are zero.
- R5: Every write is followed in the next cycle by a status poll. After an OK answer the next write comes one cycle later, so consecutive polls are 2 cycles apart. Status code 0 means OK.
- R6: Status code 3 (hard error) ends the sequence: error rises in the next cycle and no further word is written.
- R7: Status code 1 (busy) causes a re-poll BUSY_DELAY cycles after the poll cycle ends, so consecutive polls are BUSY_DELAY+1 cycles apart.
- R8: Status code 2 (would-block) causes a re-poll after the returned tick count, with zero treated as one, so consecutive polls are max(ticks,1)+1 cycles apart.
- R9: The BUSY_LIMIT-th busy answer for the same word raises error and stops, leaving later words unwritten.
- R10: The BLOCK_LIMIT-th would-block answer for the same word raises error and stops, leaving later words unwritten.
- R11: Both retry budgets are refilled at the start of each word, so up to BUSY_LIMIT-1 busy and BLOCK_LIMIT-1 would-block answers on every word still lead to done.
- R12: After reset all outputs are low. A start pulse while busy is ignored: the sequence still writes exactly four correct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| osc_cfg_i | input | 3*2 | Oscillator settings, 2 bits per source, source 0 in the low bits |
| wait_cnt_i | input | WAIT_W | Accumulation wait count placed into every word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence finished without error (held until the next start) |
| error_o | output | 1 | Last sequence aborted (held until the next start) |
| wr_en_o | output | 1 | Control-register write strobe |
| wr_data_o | output | 64 | Control word being written; zero when not writing |
| rd_req_o | output | 1 | Status poll request |
| rsp_valid_i | input | 1 | Status answer present for the current poll |
| rsp_code_i | input | 2 | 0 OK, 1 busy, 2 would-block, 3 hard error |
| rsp_ticks_i | input | TICK_W | Retry wait returned with a would-block answer |

## Verification
The embedded assertions check cycle-local rules on every cycle:
- a write strobe lasts a single cycle and never overlaps a poll;
- every write is followed by a poll;
- a hard-error answer produces error on the next edge;
- done and error are never set together;
- the retry counters stay below their limits;
- every enable pattern written is one-hot or all-ones.

Only the bench scenarios can show the properties that span a whole sequence:
- the exact bit content of each word;
- the order and total count of writes;
- the spacing between polls after each kind of answer;
- the budget refill per word;
- the point at which each limit ends the sequence.

// File: rtl/ecs_pkg.sv
// Package: shared layout constants and types for the control-word sequencer.
// Assumes a 64-bit control register; field positions below are what the
// register decodes, so they are fixed here rather than parameterised.
package ecs_pkg;
    localparam int WORD_W   = 64;
    localparam int NSRC     = 3;
    localparam int NWORDS   = NSRC + 1;
    localparam int VCO_W    = 2;
    localparam int EN_LSB   = 0;
    localparam int MODE_BIT = 3;
    localparam int VCO_LSB  = 4;
    localparam int SEL_LSB  = 6;
    localparam int SEL_VAL  = 2;
    localparam int WAIT_LSB = 8;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_WBLK = 2'd2,
        RSP_HARD = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_POLL  = 2'd2,
        ST_DELAY = 2'd3
    } st_e;
endpackage

// File: rtl/ecs_word_build.sv
// Module: builds the four control words from captured settings.
// Assumes WAIT_LSB + WAIT_W <= 64. Purely combinational.
module ecs_word_build
    import ecs_pkg::*;
#(
    parameter int WAIT_W = 16
) (
    input  logic [NSRC*VCO_W-1:0]           osc_cfg_i,
    input  logic [WAIT_W-1:0]               wait_cnt_i,
    output logic [NWORDS-1:0][WORD_W-1:0]   words_o
);
    localparam logic [WORD_W-1:0] ALL_EN = WORD_W'((1 << NSRC) - 1);

    logic [WORD_W-1:0] base;

    // Common base shared by every word: select, wait count, mode bit.
    always_comb begin
        base = (WORD_W'(SEL_VAL) << SEL_LSB)
             | (WORD_W'(wait_cnt_i) << WAIT_LSB)
             | (WORD_W'(1) << MODE_BIT);
    end

    // One per-source word: own enable plus own oscillator setting.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign words_o[i] = base
                          | (WORD_W'(osc_cfg_i[i*VCO_W +: VCO_W]) << VCO_LSB)
                          | (WORD_W'(1) << (EN_LSB + i));
    end

    // Final word: all sources enabled together.
    assign words_o[NWORDS-1] = base | (ALL_EN << EN_LSB);
endmodule

// File: rtl/ecs_retry_ctr.sv
// Module: counts retries of one answer kind for the current word.
// hit_o flags the bump that reaches LIMIT; the count saturates there.
// Assumes LIMIT >= 1.
module ecs_retry_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bump_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign hit_o = bump_i && (cnt == CW'(LIMIT - 1));

    // Retry count: cleared per word, advanced per retried answer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr_i)             cnt <= '0;
        else if (bump_i && !hit_o)  cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/ecs_delay_tmr.sv
// Module: retry delay timer. Loaded with a cycle count (zero means one);
// last_o is high in the final delay cycle. Assumes loads happen only
// when the timer is idle.
module ecs_delay_tmr #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TICK_W-1:0] val_i,
    output logic              last_o
);
    logic [TICK_W-1:0] cnt;

    assign last_o = (cnt == TICK_W'(1));

    // Down-counter for the retry wait.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load_i)     cnt <= (val_i == '0) ? TICK_W'(1) : val_i;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (cnt == '0));
endmodule

// File: rtl/entropy_ctl_seq.sv
// Module: top of the control-word sequencer. Writes four words to one
// control register and confirms each by polling the status port, with
// separate bounded retry for busy and would-block answers.
// Assumes the responder answers a poll in the cycle rd_req_o is high.
module entropy_ctl_seq
    import ecs_pkg::*;
#(
    parameter int WAIT_W      = 16,
    parameter int TICK_W      = 8,
    parameter int BUSY_LIMIT  = 4,
    parameter int BLOCK_LIMIT = 4,
    parameter int BUSY_DELAY  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NSRC*VCO_W-1:0]   osc_cfg_i,
    input  logic [WAIT_W-1:0]       wait_cnt_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    error_o,
    output logic                    wr_en_o,
    output logic [WORD_W-1:0]       wr_data_o,
    output logic                    rd_req_o,
    input  logic                    rsp_valid_i,
    input  logic [1:0]              rsp_code_i,
    input  logic [TICK_W-1:0]       rsp_ticks_i
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam logic [TICK_W-1:0] BUSY_WAIT = TICK_W'(BUSY_DELAY);

    st_e                          state;
    logic [IDX_W-1:0]             idx;
    logic [NSRC*VCO_W-1:0]        osc_q;
    logic [WAIT_W-1:0]            wait_q;
    logic [NWORDS-1:0][WORD_W-1:0] words;
    logic                         accept, take, ok_rsp, hard_rsp;
    logic                         busy_bump, blk_bump, busy_hit, blk_hit;
    logic                         ctr_clr, tmr_load, tmr_last;
    logic [TICK_W-1:0]            tmr_val;

    ecs_word_build #(.WAIT_W(WAIT_W)) u_build (
        .osc_cfg_i  (osc_q),
        .wait_cnt_i (wait_q),
        .words_o    (words)
    );

    ecs_retry_ctr #(.LIMIT(BUSY_LIMIT)) u_busy_ctr (
        .clk(clk), .rst_n(rst_n), .clr_i(ctr_clr), .bump_i(busy_bump), .hit_o(busy_hit)
    );

    ecs_retry_ctr #(.LIMIT(BLOCK_LIMIT)) u_blk_ctr (
        .clk(clk), .rst_n(rst_n), .clr_i(ctr_clr), .bump_i(blk_bump), .hit_o(blk_hit)
    );

    ecs_delay_tmr #(.TICK_W(TICK_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .last_o(tmr_last)
    );

    // Decode the answer to the current poll.
    always_comb begin
        accept    = (state == ST_IDLE) && start_i;
        take      = (state == ST_POLL) && rsp_valid_i;
        ok_rsp    = take && (rsp_code_i == RSP_OK);
        hard_rsp  = take && (rsp_code_i == RSP_HARD);
        busy_bump = take && (rsp_code_i == RSP_BUSY);
        blk_bump  = take && (rsp_code_i == RSP_WBLK);
        ctr_clr   = accept || ok_rsp;
        tmr_load  = (busy_bump && !busy_hit) || (blk_bump && !blk_hit);
        tmr_val   = busy_bump ? BUSY_WAIT : rsp_ticks_i;
    end

    // Sequencer state, word index and sticky outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            osc_q   <= '0;
            wait_q  <= '0;
            done_o  <= 1'b0;
            error_o <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    osc_q   <= osc_cfg_i;
                    wait_q  <= wait_cnt_i;
                    idx     <= '0;
                    done_o  <= 1'b0;
                    error_o <= 1'b0;
                    state   <= ST_WRITE;
                end
                ST_WRITE: state <= ST_POLL;
                ST_POLL: if (take) begin
                    if (ok_rsp) begin
                        if (idx == IDX_W'(NWORDS - 1)) begin
                            done_o <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_WRITE;
                        end
                    end else if (hard_rsp || busy_hit || blk_hit) begin
                        error_o <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_DELAY;
                    end
                end
                ST_DELAY: if (tmr_last) state <= ST_POLL;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy_o    = (state != ST_IDLE);
        wr_en_o   = (state == ST_WRITE);
        rd_req_o  = (state == ST_POLL);
        wr_data_o = wr_en_o ? words[idx] : '0;
    end

    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    assert_wr_then_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> rd_req_o);
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_req_o));
    assert_hard_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rsp_valid_i && rsp_code_i == 2'd3) |=> (error_o && !busy_o));
    assert_outcome_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
    assert_start_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (wr_en_o && !done_o && !error_o));
    assert_enable_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (($countones(wr_data_o[NSRC-1:0]) == 1) ||
                     (wr_data_o[NSRC-1:0] == {NSRC{1'b1}})));
endmodule

// File: tb/tb_entropy_ctl_seq.sv
`timescale 1ns/100ps
module tb_entropy_ctl_seq;
    localparam int BL = 3, KL = 3, BD = 2;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [5:0]  osc_cfg = '0;
    logic [15:0] wait_cnt = '0;
    logic        busy, done, err, wr_en, rd_req;
    logic [63:0] wr_data;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_code = '0;
    logic [7:0]  rsp_ticks = '0;

    always #2.5 clk = ~clk;

    entropy_ctl_seq #(.WAIT_W(16), .TICK_W(8), .BUSY_LIMIT(BL),
                      .BLOCK_LIMIT(KL), .BUSY_DELAY(BD)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .osc_cfg_i(osc_cfg),
        .wait_cnt_i(wait_cnt), .busy_o(busy), .done_o(done), .error_o(err),
        .wr_en_o(wr_en), .wr_data_o(wr_data), .rd_req_o(rd_req),
        .rsp_valid_i(rsp_valid), .rsp_code_i(rsp_code), .rsp_ticks_i(rsp_ticks)
    );

    int tests = 0, fails = 0, cyc = 0;
    int nwr = 0, npoll = 0, scr_end = 0;
    logic [63:0] wlog [0:4095];
    logic [1:0]  pl_code [0:8191];
    logic [7:0]  pl_tick [0:8191];
    int          pl_cyc  [0:8191];
    logic [1:0]  scr_code [0:8191];
    logic [7:0]  scr_tick [0:8191];

    always @(posedge clk) cyc <= cyc + 1;

    // Register and status-source model: log writes, answer polls from the script.
    always @(negedge clk) begin
        if (wr_en) begin
            wlog[nwr] <= wr_data;
            nwr <= nwr + 1;
        end
        if (rd_req) begin
            logic [1:0] c;
            logic [7:0] t;
            c = (npoll < scr_end) ? scr_code[npoll] : 2'd0;
            t = (npoll < scr_end) ? scr_tick[npoll] : 8'd0;
            rsp_valid <= 1'b1;
            rsp_code  <= c;
            rsp_ticks <= t;
            pl_code[npoll] <= c;
            pl_tick[npoll] <= t;
            pl_cyc[npoll]  <= cyc;
            npoll <= npoll + 1;
        end else begin
            rsp_valid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] c, input logic [7:0] t);
        scr_code[scr_end] = c;
        scr_tick[scr_end] = t;
        scr_end++;
    endtask

    function automatic logic [63:0] exp_word(input int k, input logic [5:0] o, input logic [15:0] w);
        logic [63:0] b;
        b = (64'd2 << 6) | (64'(w) << 8) | (64'd1 << 3);
        if (k < 3) return b | (64'(o[2*k +: 2]) << 4) | (64'd1 << k);
        return b | 64'd7;
    endfunction

    int b_wr, b_pl;

    // Launch one sequence and wait for its outcome; optional second start mid-run.
    task automatic run(input logic [5:0] o, input logic [15:0] w, input int restart_at);
        osc_cfg = o; wait_cnt = w;
        b_wr = nwr; b_pl = npoll;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        chk(busy && !done && !err, "R1 launch busy/clear", {busy, done, err}, 3'b100);
        for (int i = 0; i < 2000; i++) begin
            if (i == restart_at) begin
                start = 1'b1; osc_cfg = ~o; wait_cnt = ~w;
                @(negedge clk); start = 1'b0; #1;
            end
            if (done || err) break;
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
    endtask

    // Compare logged words and poll spacing against the requirements.
    task automatic check_words_gaps(input logic [5:0] o, input logic [15:0] w, input string tag);
        for (int k = 0; k < nwr - b_wr; k++)
            chk(wlog[b_wr+k] == exp_word(k, o, w), {tag, " R2 R3 R4 word"}, wlog[b_wr+k], exp_word(k, o, w));
        for (int p = b_pl; p + 1 < npoll; p++) begin
            int g;
            g = (pl_code[p] == 2'd1) ? BD + 1 :
                (pl_code[p] == 2'd2) ? ((pl_tick[p] == 0) ? 2 : int'(pl_tick[p]) + 1) : 2;
            chk(pl_cyc[p+1] - pl_cyc[p] == g,
                (pl_code[p] == 2'd1) ? "R7 busy gap" : (pl_code[p] == 2'd2) ? "R8 wblk gap" : "R5 ok gap",
                pl_cyc[p+1] - pl_cyc[p], g);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk({busy, done, err, wr_en, rd_req, wr_data} == '0, "R12 reset outputs", {busy, done, err, wr_en, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1-R5: all oscillator patterns, varied wait counts, every poll OK.
        for (int o = 0; o < 64; o++) begin
            logic [15:0] w;
            w = 16'((o * 1031 + 7) % 65536);
            scr_end = npoll;
            run(6'(o), w, -1);
            chk(done && !err && !busy, "R1 done", {done, err, busy}, 3'b100);
            chk(nwr - b_wr == 4, "R1 four writes", nwr - b_wr, 4);
            chk(npoll - b_pl == 4, "R5 one poll per word", npoll - b_pl, 4);
            check_words_gaps(6'(o), w, "sweep");
        end

        // R7-R10: busy and would-block counts swept on each word.
        for (int wd = 0; wd < 4; wd++)
            for (int nb = 0; nb <= BL; nb++)
                for (int nk = 0; nk <= KL; nk++) begin
                    int ew;
                    bit ee;
                    scr_end = npoll;
                    for (int k = 0; k < wd; k++) push(2'd0, 8'd0);
                    for (int k = 0; k < nb; k++) push(2'd1, 8'd9);
                    for (int k = 0; k < nk; k++) push(2'd2, 8'((nb + k) % 4));
                    run(6'(wd * 13 + nb), 16'(nk * 300 + 5), -1);
                    ee = (nb >= BL) || (nk >= KL);
                    ew = ee ? wd + 1 : 4;
                    chk(err == ee && done == !ee, ee ? "R9 R10 limit error" : "R11 recovers",
                        {done, err}, {!ee, ee});
                    chk(nwr - b_wr == ew, "R9 R10 writes left unwritten", nwr - b_wr, ew);
                    check_words_gaps(6'(wd * 13 + nb), 16'(nk * 300 + 5), "retry");
                end

        // R6: hard error on each word.
        for (int wd = 0; wd < 4; wd++) begin
            scr_end = npoll;
            for (int k = 0; k < wd; k++) push(2'd0, 8'd0);
            push(2'd3, 8'd0);
            run(6'h2d, 16'h1234, -1);
            chk(err && !done && !busy, "R6 hard error", {done, err, busy}, 3'b010);
            chk(nwr - b_wr == wd + 1, "R6 no further write", nwr - b_wr, wd + 1);
        end

        // R11: maximum allowed retries on every word still completes.
        scr_end = npoll;
        for (int k = 0; k < 4; k++) begin
            push(2'd1, 8'd0); push(2'd1, 8'd0);
            push(2'd2, 8'd3); push(2'd2, 8'd0);
            push(2'd0, 8'd0);
        end
        run(6'h1b, 16'hbeef, -1);
        chk(done && !err, "R11 per-word refill", {done, err}, 2'b10);
        chk(nwr - b_wr == 4, "R11 four writes", nwr - b_wr, 4);
        check_words_gaps(6'h1b, 16'hbeef, "refill");

        // R12: a start mid-sequence is ignored.
        scr_end = npoll;
        push(2'd0, 8'd0); push(2'd1, 8'd0); push(2'd1, 8'd0);
        run(6'h36, 16'h0f0f, 3);
        chk(done && !err, "R12 restart ignored outcome", {done, err}, 2'b10);
        chk(nwr - b_wr == 4, "R12 restart ignored writes", nwr - b_wr, 4);
        check_words_gaps(6'h36, 16'h0f0f, "R12");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule